// File: doc/BRIEF.md
# Hot-Plug Slot Connection Sequencer

This block brings one hot-pluggable expansion slot up and takes it down in a fixed order. A host register interface writes a control word. The word holds a bit for each bring-up step: power on, clock start, bus-width indication, closing the isolation switches and releasing the card reset. It also holds a mode bit that picks manual or automatic switch closing. The block checks each write against how far the slot has progressed. It accepts only the next legal step and drives the slot power enable, the active-low card reset, the active-low clock gate, the 64-bit request line and the enable of the isolation switches that join the backplane bus to the card.

After power is enabled, the sequencer waits for the supply to report power good, through a synchronizer. If the report does not arrive within a programmable number of cycles, the slot is faulted. In automatic mode an internal timer closes the switches a fixed number of cycles after the clock starts, then releases the card reset a second delay later. In manual mode both of these are software steps. Clearing the power bit at any point after power-on unwinds the slot in reverse order, with one cycle per step. A state code lets software poll until the slot is connected.

Top module: `slot_conn_seq`

## Requirements
- R1: After a synchronous reset: pwr_en=0, slot_rst_n=0, clk_gate_n=1, req64_n=1, bus_sw_en=0, seq_err=0, pwr_fault=0 and seq_state=0. The stored control word is 0x0C. Control word bits: [0] power on, [1] reset release, [2] clock run (active low), [3] width request (active low), [4] 32-bit slot, [5] manual switch close, [6] automatic mode.
- R2: In state 0, a write that sets bit 0 and leaves bits 1 to 5 unchanged raises pwr_en in the cycle after the write and moves to state 1. Bit 6 may change in the same write.
- R3: In state 1 the clock step is refused. After pwr_good is high, the state moves to 3 on the third clock edge, counting the edge that first samples pwr_good.
- R4: If power good is still low PG_TMO cycles after the power-on write, pwr_fault rises and the state moves to 2. From state 2 only a power-off write is accepted. The next accepted power-on clears pwr_fault.
- R5: In state 3, a write that clears only bit 2 drives clk_gate_n low in the next cycle (state 4). slot_rst_n stays low.
- R6: In state 4, a write that clears bit 3 moves to state 5 and sets req64_n to written bit 4: low for a 64-bit slot, high for a 32-bit slot.
- R7: In manual mode, setting bit 5 in state 5 raises bus_sw_en (state 6). Setting bit 1 in state 6 then raises slot_rst_n (state 7).
- R8: In automatic mode, bus_sw_en rises SW_DLY cycles after clk_gate_n falls, provided the width step is done by then. slot_rst_n rises RST_DLY cycles after bus_sw_en.
- R9: A write whose changes are not the single legal next step changes no output and sets the sticky seq_err. Examples are starting the clock while power is off, or closing the switches before the width step.
- R10: A write with bit 0 clear, accepted in states 1 to 7, unwinds the slot one cycle per step: bus_sw_en falls (state 8), then slot_rst_n falls (state 9), then clk_gate_n rises (state 10), then pwr_en falls and req64_n goes high (state 0).
- R11: seq_state reports 0 off, 1 awaiting power good, 2 power fault, 3 powered, 4 clock running, 5 width set, 6 switches closed, 7 connected, 8/9/10 the unwinding steps.
- R12: Writes during states 8 to 10 are ignored and do not set seq_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word (layout in R1) |
| pwr_good | input | 1 | Supply power-good report, asynchronous |
| pwr_en | output | 1 | Slot power enable |
| slot_rst_n | output | 1 | Card reset, active low |
| clk_gate_n | output | 1 | Slot clock gate, low runs the clock |
| req64_n | output | 1 | 64-bit request to the card, low for a 64-bit slot |
| bus_sw_en | output | 1 | Isolation switch enable |
| seq_state | output | 4 | Sequencer state code (R11) |
| seq_err | output | 1 | Sticky order-violation flag |
| pwr_fault | output | 1 | Power-good timeout flag |

## Verification
The bring-up is tried in three patterns, each telling different logic apart:
- A manual 64-bit bring-up, which exercises every software step and the low level of req64_n.
- An automatic 32-bit bring-up, which pins the exact edges of the switch and reset timers and the high level of req64_n.
- A power-on with power good held low, which separates the timeout path from the power-good path and shows that the fault clears on the next power-on.

Writes out of order are placed in each of these patterns at different states. A write is also placed inside the unwinding, so that refused writes, ignored writes and accepted steps are told apart by the state code and the error flag.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF    = 4'd0,
        S_PWAIT  = 4'd1,
        S_PFAIL  = 4'd2,
        S_PRDY   = 4'd3,
        S_CLKRUN = 4'd4,
        S_WIDTH  = 4'd5,
        S_SWON   = 4'd6,
        S_ACTIVE = 4'd7,
        S_DN_RST = 4'd8,
        S_DN_CLK = 4'd9,
        S_DN_PWR = 4'd10
    } seq_state_e;

    // control word, bit 0 is power_on
    typedef struct packed {
        logic auto_mode;  // [6]
        logic sw_close;   // [5]
        logic slot32;     // [4]
        logic width_n;    // [3]
        logic clk_n;      // [2]
        logic rst_rel;    // [1]
        logic power_on;   // [0]
    } ctl_word_t;

    localparam int CW_BITS = $bits(ctl_word_t);

    localparam logic [CW_BITS-1:0] M_PWR  = 7'h01;
    localparam logic [CW_BITS-1:0] M_REL  = 7'h02;
    localparam logic [CW_BITS-1:0] M_CLK  = 7'h04;
    localparam logic [CW_BITS-1:0] M_REQ  = 7'h08;
    localparam logic [CW_BITS-1:0] M_W32  = 7'h10;
    localparam logic [CW_BITS-1:0] M_SW   = 7'h20;
    localparam logic [CW_BITS-1:0] M_AUTO = 7'h40;

    localparam ctl_word_t CW_IDLE = ctl_word_t'(7'h0C);

    typedef enum logic [2:0] {
        WR_NOP,   // no change requested
        WR_STEP,  // next legal step
        WR_MODE,  // mode change while off
        WR_DOWN,  // power removal request
        WR_BAD,   // order violation
        WR_SKIP   // ignored during unwinding
    } wr_kind_e;

    typedef struct packed {
        logic pwr;
        logic rst_n;
        logic clk_n;
        logic req64_n;
        logic sw;
    } slot_drv_t;

    localparam slot_drv_t DRV_OFF = '{pwr: 1'b0, rst_n: 1'b0, clk_n: 1'b1,
                                      req64_n: 1'b1, sw: 1'b0};

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic in_unwind(input seq_state_e s);
        return (s == S_DN_RST) || (s == S_DN_CLK) || (s == S_DN_PWR);
    endfunction

endpackage

// File: rtl/slot_pg_sync.sv
module slot_pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh_q <= '0;
                else     sh_q <= {sh_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/slot_seq_timer.sv
module slot_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/slot_wr_check.sv
module slot_wr_check
    import slot_seq_pkg::*;
(
    input  seq_state_e state,
    input  ctl_word_t  cur,
    input  ctl_word_t  wd,
    output wr_kind_e   kind
);
    logic [CW_BITS-1:0] diff;

    assign diff = cur ^ wd;

    always_comb begin
        kind = WR_BAD;
        if (in_unwind(state)) begin
            kind = WR_SKIP;
        end else if (state != S_OFF && !wd.power_on) begin
            kind = WR_DOWN;
        end else if (diff == '0) begin
            kind = WR_NOP;
        end else begin
            unique case (state)
                S_OFF: begin
                    if ((diff & ~(M_PWR | M_AUTO)) != '0) kind = WR_BAD;
                    else if (wd.power_on)                 kind = WR_STEP;
                    else                                  kind = WR_MODE;
                end
                S_PRDY:   kind = (diff == M_CLK) ? WR_STEP : WR_BAD;
                S_CLKRUN: kind = ((diff & ~M_W32) == M_REQ) ? WR_STEP : WR_BAD;
                S_WIDTH:  kind = (!cur.auto_mode && diff == M_SW) ? WR_STEP : WR_BAD;
                S_SWON:   kind = (!cur.auto_mode && diff == M_REL) ? WR_STEP : WR_BAD;
                default:  kind = WR_BAD;
            endcase
        end
    end
endmodule

// File: rtl/slot_conn_seq.sv
module slot_conn_seq
    import slot_seq_pkg::*;
#(
    parameter int SW_DLY      = 16,
    parameter int RST_DLY     = 8,
    parameter int PG_TMO      = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_we,
    input  logic [CW_BITS-1:0] ctl_wdata,
    input  logic               pwr_good,
    output logic               pwr_en,
    output logic               slot_rst_n,
    output logic               clk_gate_n,
    output logic               req64_n,
    output logic               bus_sw_en,
    output logic [3:0]         seq_state,
    output logic               seq_err,
    output logic               pwr_fault
);
    localparam int TW = $clog2(max3(SW_DLY, RST_DLY, PG_TMO) + 1);
    localparam logic [TW-1:0] LD_SW  = TW'(SW_DLY - 1);
    localparam logic [TW-1:0] LD_RST = TW'(RST_DLY - 1);
    localparam logic [TW-1:0] LD_PG  = TW'(PG_TMO - 1);

    seq_state_e state_q, state_d;
    ctl_word_t  creg_q, creg_d, wd;
    slot_drv_t  drv_q, drv_d;
    logic       err_q, err_d, flt_q, flt_d;
    logic       pg_s;
    logic       tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    wr_kind_e   kind;

    assign wd = ctl_word_t'(ctl_wdata);

    slot_pg_sync #(.STAGES(SYNC_STAGES)) u_pg_sync (
        .clk (clk),
        .rst (rst),
        .din (pwr_good),
        .dout(pg_s)
    );

    slot_seq_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .done    (tmr_done)
    );

    slot_wr_check u_check (
        .state(state_q),
        .cur  (creg_q),
        .wd   (wd),
        .kind (kind)
    );

    always_comb begin
        state_d  = state_q;
        creg_d   = creg_q;
        drv_d    = drv_q;
        err_d    = err_q;
        flt_d    = flt_q;
        tmr_load = 1'b0;
        tmr_val  = '0;

        if (ctl_we && kind == WR_BAD) err_d = 1'b1;

        if (ctl_we && kind == WR_DOWN) begin
            state_d          = S_DN_RST;
            drv_d.sw         = 1'b0;
            creg_d           = CW_IDLE;
            creg_d.auto_mode = creg_q.auto_mode;
        end else if (ctl_we && kind == WR_MODE) begin
            creg_d = wd;
        end else if (ctl_we && kind == WR_STEP) begin
            creg_d = wd;
            unique case (state_q)
                S_OFF: begin
                    state_d   = S_PWAIT;
                    drv_d.pwr = 1'b1;
                    flt_d     = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_PG;
                end
                S_PRDY: begin
                    state_d     = S_CLKRUN;
                    drv_d.clk_n = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_SW;
                end
                S_CLKRUN: begin
                    state_d       = S_WIDTH;
                    drv_d.req64_n = wd.slot32;
                end
                S_WIDTH: begin
                    state_d  = S_SWON;
                    drv_d.sw = 1'b1;
                end
                S_SWON: begin
                    state_d     = S_ACTIVE;
                    drv_d.rst_n = 1'b1;
                end
                default: ;
            endcase
        end else begin
            unique case (state_q)
                S_PWAIT: begin
                    if (pg_s) begin
                        state_d = S_PRDY;
                    end else if (tmr_done) begin
                        state_d = S_PFAIL;
                        flt_d   = 1'b1;
                    end
                end
                S_WIDTH: begin
                    if (creg_q.auto_mode && tmr_done) begin
                        state_d  = S_SWON;
                        drv_d.sw = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_RST;
                    end
                end
                S_SWON: begin
                    if (creg_q.auto_mode && tmr_done) begin
                        state_d     = S_ACTIVE;
                        drv_d.rst_n = 1'b1;
                    end
                end
                S_DN_RST: begin
                    state_d     = S_DN_CLK;
                    drv_d.rst_n = 1'b0;
                end
                S_DN_CLK: begin
                    state_d     = S_DN_PWR;
                    drv_d.clk_n = 1'b1;
                end
                S_DN_PWR: begin
                    state_d = S_OFF;
                    drv_d   = DRV_OFF;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_OFF;
            creg_q  <= CW_IDLE;
            drv_q   <= DRV_OFF;
            err_q   <= 1'b0;
            flt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            creg_q  <= creg_d;
            drv_q   <= drv_d;
            err_q   <= err_d;
            flt_q   <= flt_d;
        end
    end

    assign pwr_en     = drv_q.pwr;
    assign slot_rst_n = drv_q.rst_n;
    assign clk_gate_n = drv_q.clk_n;
    assign req64_n    = drv_q.req64_n;
    assign bus_sw_en  = drv_q.sw;
    assign seq_state  = state_q;
    assign seq_err    = err_q;
    assign pwr_fault  = flt_q;

    // ordering guards
    a_r5_clk_needs_pwr: assert property (@(posedge clk) disable iff (rst)
        !clk_gate_n |-> pwr_en);

    a_r3_clk_after_ready: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_gate_n) |-> $past(state_q) == S_PRDY);

    a_r7_sw_needs_clk: assert property (@(posedge clk) disable iff (rst)
        bus_sw_en |-> (!clk_gate_n && pwr_en));

    a_r7_release_needs_sw: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_rst_n) |-> bus_sw_en);

    a_r10_power_last: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_en) |-> (clk_gate_n && !slot_rst_n && !bus_sw_en));

    a_r10_clk_stop_after_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_gate_n) |-> (!slot_rst_n && !bus_sw_en));

    a_r9_bad_write_flags: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && kind == WR_BAD) |=> seq_err);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    a_r12_unwind_ignores_writes: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && in_unwind(state_q)) |=> (creg_q == $past(creg_q) && seq_err == $past(seq_err)));

endmodule

// File: tb/slot_conn_seq_bench.sv
module slot_conn_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [6:0] ctl_wdata = 7'h0C;
    logic       pwr_good = 1'b0;
    logic       pwr_en, slot_rst_n, clk_gate_n, req64_n, bus_sw_en, seq_err, pwr_fault;
    logic [3:0] seq_state;

    slot_conn_seq #(.SW_DLY(4), .RST_DLY(3), .PG_TMO(10), .SYNC_STAGES(2)) u_slot_conn_seq (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .pwr_good(pwr_good), .pwr_en(pwr_en), .slot_rst_n(slot_rst_n),
        .clk_gate_n(clk_gate_n), .req64_n(req64_n), .bus_sw_en(bus_sw_en),
        .seq_state(seq_state), .seq_err(seq_err), .pwr_fault(pwr_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        logic [10:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    localparam logic [6:0] W_IDLE = 7'h0C;
    localparam logic [6:0] W_PWR  = 7'h0D;
    localparam logic [6:0] W_CLK  = 7'h09;
    localparam logic [6:0] W_W64  = 7'h01;
    localparam logic [6:0] W_SW   = 7'h21;
    localparam logic [6:0] W_REL  = 7'h23;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [10:0] ob(input int st, input bit p, input bit r, input bit c,
                                       input bit q64, input bit sw, input bit e, input bit f);
        return {st[3:0], p, r, c, q64, sw, e, f};
    endfunction

    // monitor: compares outputs against queued expectations
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                exp_t e;
                logic [10:0] got;
                e   = q.pop_front();
                got = {seq_state, pwr_en, slot_rst_n, clk_gate_n, req64_n, bus_sw_en, seq_err, pwr_fault};
                n_cmp++;
                if (got !== e.val) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h (cycle %0d)", e.tag, got, e.val, cyc);
                end
            end
        end
    end

    // driver: applies one cycle of stimulus and queues the result expected after the next edge
    task automatic step(input bit we, input logic [6:0] d, input logic [10:0] ev, input string tag);
        ctl_we    = we;
        ctl_wdata = d;
        q.push_back('{cyc + 1, ev, tag});
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step(1'b0, W_IDLE, ob(0,0,0,1,1,0,0,0), "R1 reset state");
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();
        step(1'b1, 7'h08, ob(0,0,0,1,1,0,1,0), "R9 clock while power off");
        do_reset();

        // manual 64-bit bring-up
        step(1'b1, W_PWR, ob(1,1,0,1,1,0,0,0), "R2 power on");
        step(1'b1, W_CLK, ob(1,1,0,1,1,0,1,0), "R3 clock refused before power good");
        pwr_good = 1'b1;
        step(1'b0, W_CLK, ob(1,1,0,1,1,0,1,0), "R3 sync stage 1");
        step(1'b0, W_CLK, ob(1,1,0,1,1,0,1,0), "R3 sync stage 2");
        step(1'b0, W_CLK, ob(3,1,0,1,1,0,1,0), "R3 R11 powered");
        step(1'b1, W_CLK, ob(4,1,0,0,1,0,1,0), "R5 clock on reset held");
        step(1'b1, 7'h29, ob(4,1,0,0,1,0,1,0), "R9 switch before width");
        step(1'b1, W_W64, ob(5,1,0,0,0,0,1,0), "R6 64-bit width");
        step(1'b1, W_SW,  ob(6,1,0,0,0,1,1,0), "R7 manual switch close");
        step(1'b1, W_REL, ob(7,1,1,0,0,1,1,0), "R7 R11 manual release");
        step(1'b1, 7'h00, ob(8,1,1,0,0,0,1,0), "R10 switches open first");
        step(1'b1, W_PWR, ob(9,1,0,0,0,0,1,0), "R12 write ignored R10 reset asserted");
        step(1'b0, W_PWR, ob(10,1,0,1,0,0,1,0), "R10 clock stopped");
        step(1'b0, W_PWR, ob(0,0,0,1,1,0,1,0), "R10 power removed");

        // automatic 32-bit bring-up
        do_reset();
        step(1'b1, 7'h4D, ob(1,1,0,1,1,0,0,0), "R2 power on automatic mode");
        step(1'b0, 7'h4D, ob(3,1,0,1,1,0,0,0), "R3 powered");
        step(1'b1, 7'h49, ob(4,1,0,0,1,0,0,0), "R5 clock on");
        step(1'b1, 7'h51, ob(5,1,0,0,1,0,0,0), "R6 32-bit width");
        step(1'b0, 7'h51, ob(5,1,0,0,1,0,0,0), "R8 switches still open");
        step(1'b0, 7'h51, ob(5,1,0,0,1,0,0,0), "R8 switches still open");
        step(1'b0, 7'h51, ob(6,1,0,0,1,1,0,0), "R8 switches close at SW_DLY");
        step(1'b0, 7'h51, ob(6,1,0,0,1,1,0,0), "R8 reset held");
        step(1'b0, 7'h51, ob(6,1,0,0,1,1,0,0), "R8 reset held");
        step(1'b0, 7'h51, ob(7,1,1,0,1,1,0,0), "R8 release at RST_DLY");
        step(1'b1, 7'h71, ob(7,1,1,0,1,1,1,0), "R9 manual switch bit in automatic mode");
        step(1'b1, 7'h40, ob(8,1,1,0,1,0,1,0), "R10 switches open");
        step(1'b0, 7'h40, ob(9,1,0,0,1,0,1,0), "R10 reset asserted");
        step(1'b0, 7'h40, ob(10,1,0,1,1,0,1,0), "R10 clock stopped");
        step(1'b0, 7'h40, ob(0,0,0,1,1,0,1,0), "R10 power removed");

        // power-good timeout
        pwr_good = 1'b0;
        do_reset();
        step(1'b1, W_PWR, ob(1,1,0,1,1,0,0,0), "R2 power on");
        for (int i = 0; i < 8; i++) @(negedge clk);
        step(1'b0, W_PWR, ob(1,1,0,1,1,0,0,0), "R4 no fault before timeout");
        step(1'b0, W_PWR, ob(2,1,0,1,1,0,0,1), "R4 fault at timeout");
        step(1'b1, W_CLK, ob(2,1,0,1,1,0,1,1), "R4 clock refused after fault");
        step(1'b1, W_IDLE, ob(8,1,0,1,1,0,1,1), "R10 unwind from fault");
        step(1'b0, W_IDLE, ob(9,1,0,1,1,0,1,1), "R10 unwind");
        step(1'b0, W_IDLE, ob(10,1,0,1,1,0,1,1), "R10 unwind");
        step(1'b0, W_IDLE, ob(0,0,0,1,1,0,1,1), "R10 off with fault kept");
        step(1'b1, W_PWR, ob(1,1,0,1,1,0,1,0), "R4 fault cleared by power on");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL pending: actual %0d left expected 0", q.size());
        end
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule